// File: doc/BRIEF.md
# I2C Target with Persistent Command Pointer

This block is the serial front end of a small port expander. It samples the two-wire bus lines (SCL and SDA) with the system clock and filters out short spikes. It detects START, repeated START and STOP conditions and matches a fixed 7-bit device address. For a write, the first byte after the address is a command byte. That byte selects one of the four registers in a neighbouring register bank. Each byte that follows becomes a write strobe to that register. For a read, each byte comes from the register the pointer selects, and the block raises a read strobe for every byte it fetches.

The pointer never moves on its own. It holds its value across data bytes, across repeated STARTs and across whole transfers, and only a new command byte changes it. The register bank therefore sees a plain strobe interface of read, write, address and data. SDA is modelled as an open-drain pull-down enable. The block never stretches the clock.

Top module: `i2c_cmd_target`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge, `sda_oe_o` is 0, `reg_wr_o` and `reg_rd_o` are 0, and `reg_addr_o` is 0.
- R2: The block acknowledges an address byte only if its upper seven bits equal `DEV_ADDR` (default 7'h49). Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read. After an address that does not match, the block acknowledges nothing and writes nothing until the next START.
- R3: In a write, the first byte after the address is the command byte. If its value is below `NUM_REGS` (4), the block acknowledges it and loads it into the pointer (`reg_addr_o`). If its value is larger, the block does not acknowledge it and the pointer keeps its old value.
- R4: Each further byte of a write is acknowledged. It produces exactly one `reg_wr_o` pulse carrying that byte on `reg_wdata_o` and the current pointer on `reg_addr_o`. Bits arrive MSB first, and the pointer does not advance between bytes.
- R5: Each byte of a read is the value of `reg_rdata_i` for the current pointer, shifted out MSB first. Every byte fetched gives one `reg_rd_o` pulse. After a master ACK (SDA low) the block sends the same register again; after a master NACK it goes idle.
- R6: The pointer keeps its value across STOP and repeated START. A repeated START sends the block back to address matching, so a read with no new command byte returns the register selected earlier.
- R7: A STOP at a byte boundary or in the middle of a byte sends the block to idle. It releases SDA and produces no register write for the unfinished byte.
- R8: The block ignores a pulse on SCL or SDA that lasts fewer than `FILT_CYC` clock cycles (10 cycles, 50 ns at 200 MHz).
- R9: `sda_oe_o` rises only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe, one per byte fetched |
| reg_addr_o | output | PTR_W | Command pointer (register select) |
| reg_wdata_o | output | 8 | Write data for the register bank |
| reg_rdata_i | input | 8 | Read data of the register selected by `reg_addr_o` |

## Verification
A raw SCL or SDA edge reaches the byte engine after two synchroniser stages, `FILT_CYC` filter cycles and one edge-detect register. That is about 13 clocks, so a new SDA level from the block appears about 13 clocks after the master lowers SCL. A `reg_wr_o` or `reg_rd_o` pulse appears one clock after the filtered SCL falling edge that ends the byte or the acknowledge. The bench master holds each quarter-bit for 30 clocks. It samples SDA one full quarter after raising SCL, so every response has settled by then. A monitor compares every strobe on every clock against a queue of expected writes and the pointer the bench model expects. All port checks are made at falling clock edges, away from the edge where the design updates.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C command-pointer target.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    // Byte-engine states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // receiving address byte
        ST_CMD,    // receiving command byte
        ST_WDATA,  // receiving write data
        ST_ACK,    // driving our acknowledge bit
        ST_RDATA,  // shifting out a read byte
        ST_RACK    // sampling the master's acknowledge
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_filter.sv
// Two-flop synchroniser followed by a persistence filter for one bus line.
// The output takes a new level only after the synchronised input has held
// that level for FILT_CYC consecutive clocks. Assumes the line idles high.
module i2c_tgt_filter #(
    parameter int FILT_CYC = 10,
    localparam int CW = $clog2(FILT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic        sync_a, sync_b;
    logic [CW-1:0] hold_cnt;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= din;
            sync_b <= sync_a;
        end
    end

    // Accept a new level once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            dout     <= 1'b1;
        end else if (sync_b == dout) begin
            hold_cnt <= '0;
        end else if (hold_cnt == CW'(FILT_CYC - 1)) begin
            hold_cnt <= '0;
            dout     <= sync_b;
        end else begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
// Bus-condition detector on the filtered lines: SCL edges, START and STOP.
// Assumes both filtered lines have equal delay, so their order is preserved.
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges and conditions from previous and current levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & ~sda_f & sda_q;
        stop_det  = scl_f & scl_q & sda_f & ~sda_q;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte engine: address match, command pointer, write strobes, read shifting
// and acknowledge handling. Samples SDA on filtered SCL rise and changes its
// SDA drive only on filtered SCL fall. The pointer never auto-increments.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h49,
    parameter int         NUM_REGS = 4,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              sda_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              cmd_phase_o
);
    tgt_state_t        state, ack_next;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [3:0]        bit_cnt;
    logic              mst_ack;

    assign cmd_phase_o = (state == ST_CMD);

    // Main sequencer; START and STOP take priority over bit activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ack_next    <= ST_IDLE;
            rx_sh       <= '0;
            tx_sh       <= '0;
            bit_cnt     <= '0;
            ptr_o       <= '0;
            sda_oe_o    <= 1'b0;
            reg_wr_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
            reg_wdata_o <= '0;
            mst_ack     <= 1'b0;
        end else begin
            reg_wr_o <= 1'b0;
            reg_rd_o <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                    ack_next <= rx_sh[0] ? ST_RDATA : ST_CMD;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CMD) begin
                                if (int'(rx_sh) < NUM_REGS) begin
                                    ptr_o    <= rx_sh[PTR_W-1:0];
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACK;
                                    ack_next <= ST_WDATA;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                reg_wr_o    <= 1'b1;
                                reg_wdata_o <= rx_sh;
                                sda_oe_o    <= 1'b1;
                                state       <= ST_ACK;
                                ack_next    <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ack_next;
                            if (ack_next == ST_RDATA) begin
                                tx_sh    <= reg_rdata_i;
                                sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
                                bit_cnt  <= 4'd1;
                                reg_rd_o <= 1'b1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                sda_oe_o <= ~tx_sh[BYTE_W-2];
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                state    <= ST_RDATA;
                                tx_sh    <= reg_rdata_i;
                                sda_oe_o <= ~reg_rdata_i[BYTE_W-1];
                                bit_cnt  <= 4'd1;
                                reg_rd_o <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_target.sv
// Top of the I2C command-pointer target. Filters both bus lines, detects
// bus conditions and runs the byte engine that drives a register strobe bus.
// Assumes reg_rdata_i follows reg_addr_o combinationally in the register bank.
module i2c_cmd_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h49,
    parameter int         FILT_CYC = 10,
    parameter int         NUM_REGS = 4,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    logic [1:0] line_raw, line_filt;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       cmd_phase;

    assign line_raw = {scl_i, sda_i};
    assign scl_f    = line_filt[1];
    assign sda_f    = line_filt[0];

    // One synchroniser and spike filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_tgt_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[g]),
            .dout (line_filt[g])
        );
    end

    i2c_tgt_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_f      (sda_f),
        .reg_rdata_i(reg_rdata_i),
        .sda_oe_o   (sda_oe_o),
        .reg_wr_o   (reg_wr_o),
        .reg_rd_o   (reg_rd_o),
        .reg_wdata_o(reg_wdata_o),
        .ptr_o      (reg_addr_o),
        .cmd_phase_o(cmd_phase)
    );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
// Protocol checker for the I2C command-pointer target, bound to the top.
module i2c_cmd_target_chk #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             start_det,
    input logic             stop_det,
    input logic             cmd_phase,
    input logic             sda_oe_o,
    input logic             reg_wr_o,
    input logic             reg_rd_o,
    input logic [PTR_W-1:0] reg_addr_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe_o && !reg_wr_o && !reg_rd_o && reg_addr_o == '0));

    // R9
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_f);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && !reg_wr_o));

    // R6
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R3
    ptr_only_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr_o) |-> ($past(cmd_phase) || !$past(rst_n)));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.PTR_W(PTR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cmd_phase (cmd_phase),
    .sda_oe_o  (sda_oe_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o),
    .reg_addr_o(reg_addr_o)
);

// File: tb/test_i2c_cmd_target.sv
`timescale 1ns/1ps
// Bench: behavioural bus master, register-bank model and per-clock strobe monitor.
module test_i2c_cmd_target;
    localparam int Q = 30;           // clocks per quarter bit
    localparam logic [6:0] ADDR = 7'h49;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe_o, reg_wr_o, reg_rd_o;
    logic [1:0] reg_addr_o;
    logic [7:0] reg_wdata_o, reg_rdata_i;
    logic [7:0] bank [4];
    logic [3:0] pins = 4'h0;

    int checks = 0;
    int errors = 0;
    int rd_seen = 0;
    int exp_ptr = 0;
    logic [9:0] wq [$];

    always #2.5 clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe_o;
    assign reg_rdata_i = (reg_addr_o == 2'd0) ? {4'hF, pins} : bank[reg_addr_o];

    i2c_cmd_target i_i2c_cmd_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .reg_wr_o   (reg_wr_o),
        .reg_rd_o   (reg_rd_o),
        .reg_addr_o (reg_addr_o),
        .reg_wdata_o(reg_wdata_o),
        .reg_rdata_i(reg_rdata_i)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Per-clock monitor of register strobes against the model.
    always @(negedge clk) begin
        if (rst_n && reg_wr_o) begin
            if (wq.size() == 0) begin
                check("R4 unexpected write", {22'd0, reg_addr_o, reg_wdata_o}, 0);
            end else begin
                check("R4 write addr/data", {22'd0, reg_addr_o, reg_wdata_o}, {22'd0, wq.pop_front()});
            end
            bank[reg_addr_o] = reg_wdata_o;
        end
        if (rst_n && reg_rd_o) begin
            rd_seen++;
            check("R5 read strobe pointer", reg_addr_o, exp_ptr);
        end
    end

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_bit(input logic b, input logic spike);
        sda_m = b;
        if (spike) begin
            repeat (Q / 2) @(negedge clk);
            scl_m = 1'b1;
            repeat (4) @(negedge clk);
            scl_m = 1'b0;
            repeat (Q - Q / 2 - 4) @(negedge clk);
        end else begin
            wait_q(1);
        end
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        b = sda_line; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic write_byte(input logic [7:0] d, input logic spike, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i], spike && i == 7);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~mack, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         rd_before;
        bank[0] = 8'h00; bank[1] = 8'hFF; bank[2] = 8'h00; bank[3] = 8'hFF;

        // R1: reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sda_oe after reset", sda_oe_o, 0);
        check("R1 pointer after reset", reg_addr_o, 0);
        check("R1 strobes after reset", {reg_wr_o, reg_rd_o}, 0);
        wait_q(2);

        // R2/R3/R4: write command 1 then data A5
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack); check("R2 address ack", ack, 1);
        write_byte(8'h01, 1'b0, ack);        check("R3 command ack", ack, 1);
        exp_ptr = 1;
        check("R3 pointer loaded", reg_addr_o, 1);
        wq.push_back({2'd1, 8'hA5});
        write_byte(8'hA5, 1'b0, ack);        check("R4 data ack", ack, 1);
        bus_stop();
        check("R4 write A5 consumed", wq.size(), 0);

        // R4: two data bytes hit the same register
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h03, 1'b0, ack); exp_ptr = 3;
        wq.push_back({2'd3, 8'h0F});
        write_byte(8'h0F, 1'b0, ack); check("R4 first data ack", ack, 1);
        wq.push_back({2'd3, 8'hF0});
        write_byte(8'hF0, 1'b0, ack); check("R4 second data ack", ack, 1);
        bus_stop();
        check("R4 no auto-increment", reg_addr_o, 3);
        check("R4 both writes consumed", wq.size(), 0);

        // R5/R6: read without new command, ACK then NACK
        rd_before = rd_seen;
        bus_start();
        write_byte({ADDR, 1'b1}, 1'b0, ack); check("R2 read address ack", ack, 1);
        read_byte(d, 1'b1); check("R6 read keeps pointer byte 1", d, 8'hF0);
        read_byte(d, 1'b0); check("R5 repeat same register byte 2", d, 8'hF0);
        bus_stop();
        check("R5 read strobe count", rd_seen - rd_before, 2);
        check("R5 sda released after NACK", sda_oe_o, 0);

        // R6: command 0 then repeated START into a read
        pins = 4'h6;
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h00, 1'b0, ack); exp_ptr = 0;
        bus_start();
        write_byte({ADDR, 1'b1}, 1'b0, ack); check("R6 address ack after repeated START", ack, 1);
        read_byte(d, 1'b0); check("R6 input register via repeated START", d, 8'hF6);
        bus_stop();

        // R2: non-matching address ignored until START
        bus_start();
        write_byte({7'h4A, 1'b0}, 1'b0, ack); check("R2 wrong address no ack", ack, 0);
        write_byte(8'h01, 1'b0, ack);         check("R2 ignored after wrong address", ack, 0);
        bus_stop();
        check("R2 pointer untouched", reg_addr_o, 0);

        // R3: command above range not acknowledged, pointer kept
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h05, 1'b0, ack); check("R3 bad command no ack", ack, 0);
        bus_stop();
        check("R3 pointer unchanged", reg_addr_o, 0);
        bus_start();
        write_byte({ADDR, 1'b1}, 1'b0, ack);
        read_byte(d, 1'b0); check("R3 read after bad command", d, 8'hF6);
        bus_stop();

        // R7: STOP inside a data byte
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h02, 1'b0, ack); exp_ptr = 2;
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b1 & 1'b0); send_bit(1'b1, 1'b0);
        bus_stop();
        check("R7 sda released after mid-byte STOP", sda_oe_o, 0);
        bus_start();
        write_byte({ADDR, 1'b1}, 1'b0, ack); check("R7 address ack after STOP", ack, 1);
        read_byte(d, 1'b0); check("R7 no write from partial byte", d, 8'h00);
        bus_stop();

        // R8: SDA spike in idle is not a START
        sda_m = 1'b0; repeat (4) @(negedge clk); sda_m = 1'b1; wait_q(1);
        scl_m = 1'b0; wait_q(1);
        write_byte({ADDR, 1'b0}, 1'b0, ack); check("R8 SDA spike not a START", ack, 0);
        bus_stop();

        // R8: SCL spike inside a data byte adds no bit
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h02, 1'b0, ack);
        wq.push_back({2'd2, 8'h3C});
        write_byte(8'h3C, 1'b1, ack); check("R8 data ack with SCL spike", ack, 1);
        bus_stop();
        check("R8 write with SCL spike consumed", wq.size(), 0);

        // R1: reset in the middle of a transfer
        bus_start();
        write_byte({ADDR, 1'b0}, 1'b0, ack);
        write_byte(8'h03, 1'b0, ack); exp_ptr = 3;
        check("R3 pointer before reset", reg_addr_o, 3);
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; exp_ptr = 0;
        @(negedge clk);
        check("R1 pointer cleared by reset", reg_addr_o, 0);
        check("R1 sda released by reset", sda_oe_o, 0);
        bus_stop();
        bus_start();
        write_byte({ADDR, 1'b1}, 1'b0, ack);
        read_byte(d, 1'b0); check("R1 read after reset uses register 0", d, 8'hF6);
        bus_stop();

        check("R4 write queue empty at end", wq.size(), 0);
        finish_run();
    end
endmodule